// File: doc/BRIEF.md
# Write-Masked GPIO Register Bank

This block is the register file of a 32-pin general-purpose I/O bank on a simple 32-bit register bus. Each 32-pin logical register takes two bus words. The word at the register's base offset holds pins 0-15. The word at base + 4 holds pins 16-31. Pin n sits at bit n mod 16 of its word.

A bus write uses its lower half as data and its upper half as a per-bit enable. Software can therefore change any set of pins in one write, with no read-modify-write. The bank holds the output value and the output-enable registers and drives them onto the pins. Pin inputs pass through a synchronizer before they can be read back.

Interrupt detection is not part of the block. Its configuration registers are exported as plain outputs. Its status inputs are readable, and an end-of-interrupt write turns into a one-cycle clear pulse.

Top module: `gpio_wm_bank`

## Requirements
- R1: After reset, every writable register is zero. pin_o, pin_oe_o, all configuration outputs and eoi_o are all zero.
- R2: A write changes data bit k (k in 0..15) of the addressed half only when wdata_i[k+16] is 1. Bits whose enable is 0 keep their value. Enable 0xFFFF loads all 16 bits at once.
- R3: An address with bit 2 clear selects pins 0-15 of a register. The same address with bit 2 set selects pins 16-31. Pin n maps to data bit n mod 16.
- R4: A read returns the selected 16 pin bits in rdata_o[15:0], and rdata_o[31:16] always reads zero.
- R5: pin_o follows the output data register (offset 0x00). pin_oe_o follows the direction register (offset 0x08), where 1 means output and 0 means input.
- R6: The configuration registers and their outputs are: 0x10 irq_en_o, 0x18 irq_mask_o, 0x20 irq_level_o, 0x28 irq_pol_o, 0x30 irq_both_o, 0x38 debounce_o. Each one reads back what was written.
- R7: Offsets 0x50 and 0x58 read irq_status_i and irq_raw_i. Writes to 0x50, 0x58 and 0x70 change no register and no output.
- R8: Offset 0x70 reads pin_i through a two-flop synchronizer. A value applied before clock edge k becomes readable after edge k+1.
- R9: A write to 0x60 or 0x64 raises eoi_o for exactly the cycle after the write edge. Only the pins whose enable bit and data bit are both 1 go high. Offset 0x60 always reads zero.
- R10: These accesses read zero and are ignored on write: any address with bits [1:0] non-zero, any address at or above 0x80, and the unused offsets 0x40, 0x48, 0x68 and 0x78.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address of the bus access |
| wdata_i | input | 32 | Write data: [31:16] enables, [15:0] data |
| we_i | input | 1 | Write strobe, one write per cycle it is high |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | 32 | Pin input levels (asynchronous) |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables |
| irq_status_i | input | 32 | Masked interrupt status, readable |
| irq_raw_i | input | 32 | Raw interrupt status, readable |
| irq_en_o | output | 32 | Interrupt enable configuration |
| irq_mask_o | output | 32 | Interrupt mask configuration |
| irq_level_o | output | 32 | Level/edge type configuration |
| irq_pol_o | output | 32 | Polarity configuration |
| irq_both_o | output | 32 | Both-edge configuration |
| debounce_o | output | 32 | Debounce enable configuration |
| eoi_o | output | 32 | One-cycle end-of-interrupt clear pulse |

## Verification
The bench writes patterns whose enable halves cover only part of the data half. A design that ignored the mask, or applied it to the wrong half, would change pins that should hold. It writes distinct values to the two words of each register, so a swapped half or a pin index not reduced mod 16 would show up on the pin outputs and on readback. It also checks three timing cases:
- the exact cycle a pin input becomes visible, which catches a missing or extra synchronizer stage;
- that the clear pulse lasts one cycle;
- that read-only, misaligned and out-of-range writes leave every output untouched.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;
  // register index = addr[6:3]; addr[2] picks the pin half
  typedef enum logic [3:0] {
    RI_DOUT  = 4'd0,
    RI_DIR   = 4'd1,
    RI_IEN   = 4'd2,
    RI_IMASK = 4'd3,
    RI_ITYPE = 4'd4,
    RI_IPOL  = 4'd5,
    RI_IBOTH = 4'd6,
    RI_DEB   = 4'd7,
    RI_STAT  = 4'd10,
    RI_RAW   = 4'd11,
    RI_EOI   = 4'd12,
    RI_EXT   = 4'd14
  } reg_idx_e;

  localparam int unsigned N_WR_REGS = 8;  // indices 0..7 are writable
endpackage

// File: rtl/gpio_wm_reg.sv
module gpio_wm_reg #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic [2*HALF_W-1:0] q_o
);
  localparam int unsigned W = 2 * HALF_W;

  logic [HALF_W-1:0] wen, wval;
  assign wval = wdata_i[HALF_W-1:0];
  assign wen  = wdata_i[W-1:HALF_W];

  logic [1:0] wr_sel;
  assign wr_sel = {wr_hi_i, wr_lo_i};

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_q <= '0;
      else if (wr_sel[h]) q_q <= (q_q & ~wen) | (wval & wen);
    end
    assign q_o[h*HALF_W +: HALF_W] = q_q;
  end

  // R2: bits with a clear enable hold across a write
  a_r2_masked_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (((q_o[HALF_W-1:0] ^ $past(q_o[HALF_W-1:0])) & ~$past(wen)) == '0));
  a_r2_masked_bits_hold_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (((q_o[W-1:HALF_W] ^ $past(q_o[W-1:HALF_W])) & ~$past(wen)) == '0));
  // R3: a write to one half never disturbs the other
  a_r3_other_half_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> $stable(q_o[W-1:HALF_W]));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end
  assign q_o = stg_q[STAGES-1];

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R8: the first stage captures the pin value of the previous cycle
  a_r8_first_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (stg_q[0] == $past(d_i)));
endmodule

// File: rtl/gpio_wm_bank.sv
module gpio_wm_bank
  import gpio_wm_pkg::*;
#(
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  input  logic                we_i,
  output logic [2*HALF_W-1:0] rdata_o,
  input  logic [2*HALF_W-1:0] pin_i,
  output logic [2*HALF_W-1:0] pin_o,
  output logic [2*HALF_W-1:0] pin_oe_o,
  input  logic [2*HALF_W-1:0] irq_status_i,
  input  logic [2*HALF_W-1:0] irq_raw_i,
  output logic [2*HALF_W-1:0] irq_en_o,
  output logic [2*HALF_W-1:0] irq_mask_o,
  output logic [2*HALF_W-1:0] irq_level_o,
  output logic [2*HALF_W-1:0] irq_pol_o,
  output logic [2*HALF_W-1:0] irq_both_o,
  output logic [2*HALF_W-1:0] debounce_o,
  output logic [2*HALF_W-1:0] eoi_o
);
  localparam int unsigned W = 2 * HALF_W;

  logic       mapped;
  logic [3:0] idx;
  logic       hi;

  assign idx = addr_i[6:3];
  assign hi  = addr_i[2];
  if (ADDR_W > 7) begin : g_hi_addr
    assign mapped = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:7] == '0);
  end else begin : g_no_hi_addr
    assign mapped = (addr_i[1:0] == 2'b00);
  end

  logic wr_ok;
  assign wr_ok = we_i && mapped;

  logic [W-1:0] regs [N_WR_REGS];

  for (genvar g = 0; g < N_WR_REGS; g++) begin : g_reg
    logic sel;
    assign sel = wr_ok && (idx == 4'(g));
    gpio_wm_reg #(.HALF_W(HALF_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_lo_i(sel && !hi),
      .wr_hi_i(sel && hi),
      .wdata_i(wdata_i),
      .q_o    (regs[g])
    );
  end

  assign pin_o       = regs[RI_DOUT];
  assign pin_oe_o    = regs[RI_DIR];
  assign irq_en_o    = regs[RI_IEN];
  assign irq_mask_o  = regs[RI_IMASK];
  assign irq_level_o = regs[RI_ITYPE];
  assign irq_pol_o   = regs[RI_IPOL];
  assign irq_both_o  = regs[RI_IBOTH];
  assign debounce_o  = regs[RI_DEB];

  logic [W-1:0] ext_sync;
  gpio_in_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (ext_sync)
  );

  // end-of-interrupt: registered single-cycle pulse of enabled ones
  logic [HALF_W-1:0] eoi_bits;
  logic              eoi_wr;
  assign eoi_bits = wdata_i[HALF_W-1:0] & wdata_i[W-1:HALF_W];
  assign eoi_wr   = wr_ok && (idx == RI_EOI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     eoi_o <= '0;
    else if (!eoi_wr) eoi_o <= '0;
    else if (hi)     eoi_o <= {eoi_bits, {HALF_W{1'b0}}};
    else             eoi_o <= {{HALF_W{1'b0}}, eoi_bits};
  end

  logic [W-1:0] rsel;
  always_comb begin
    rsel = '0;
    if (mapped) begin
      if (idx < 4'(N_WR_REGS)) rsel = regs[idx[2:0]];
      else begin
        case (idx)
          RI_STAT: rsel = irq_status_i;
          RI_RAW:  rsel = irq_raw_i;
          RI_EXT:  rsel = ext_sync;
          default: rsel = '0;
        endcase
      end
    end
  end

  assign rdata_o = {{HALF_W{1'b0}}, (hi ? rsel[W-1:HALF_W] : rsel[HALF_W-1:0])};

  // R7: writes to read-only offsets leave every output alone
  a_r7_ro_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mapped && (idx == RI_STAT || idx == RI_RAW || idx == RI_EXT))
    |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(irq_en_o) && $stable(debounce_o)));
  // R10: unmapped writes leave every output alone
  a_r10_unmapped_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mapped) |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(irq_mask_o)
                           && (eoi_o == '0)));
  // R9: the clear pulse lasts one cycle
  a_r9_eoi_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eoi_o != '0) && !we_i) |=> (eoi_o == '0));
  // R5: the pin drivers only move after a write
  a_r5_pins_need_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pin_o) && $stable(pin_oe_o)));
endmodule

// File: tb/gpio_wm_bank_tb.sv
module gpio_wm_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [31:0] stat = '0, raw = '0;
  logic [31:0] ien, imask, ilevel, ipol, iboth, deb, eoi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_wm_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .irq_status_i(stat), .irq_raw_i(raw), .irq_en_o(ien), .irq_mask_o(imask),
    .irq_level_o(ilevel), .irq_pol_o(ipol), .irq_both_o(iboth),
    .debounce_o(deb), .eoi_o(eoi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] cfg_out(input int i);
    case (i)
      2: return ien;
      3: return imask;
      4: return ilevel;
      5: return ipol;
      6: return iboth;
      default: return deb;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pin_o", pin_out, 0);
    chk("R1 pin_oe_o", pin_oe, 0);
    chk("R1 irq_en_o", ien, 0);
    chk("R1 debounce_o", deb, 0);
    chk("R1 eoi_o", eoi, 0);
    rd(8'h08, v); chk("R1 dir readback", v, 0);
  endtask

  task automatic t_mask();
    wr(8'h00, 32'h00FF_FFFF);
    chk("R2 partial enable", pin_out, 32'h0000_00FF);
    wr(8'h00, 32'h0003_0002);
    chk("R2 two-bit enable", pin_out, 32'h0000_00FE);
    wr(8'h00, 32'h0000_FFFF);
    chk("R2 zero enable", pin_out, 32'h0000_00FE);
  endtask

  task automatic t_halves();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_A5A5);
    chk("R3 upper half write", pin_out, 32'hA5A5_00FE);
    rd(8'h04, v); chk("R4 upper read", v, 32'h0000_A5A5);
    rd(8'h00, v); chk("R4 lower read", v, 32'h0000_00FE);
    wr(8'h00, 32'hFFFF_1234);
    chk("R2 full enable", pin_out, 32'hA5A5_1234);
  endtask

  task automatic t_dir();
    wr(8'h08, 32'hFFFF_000F);
    wr(8'h0C, 32'h8000_8000);
    chk("R5 output enables", pin_oe, 32'h8000_000F);
    chk("R5 pin_o unchanged", pin_out, 32'hA5A5_1234);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    for (int i = 2; i < 8; i++) begin
      wr(8'(i*8),     32'hFFFF_0000 | 32'(i*16'h1111));
      wr(8'(i*8 + 4), 32'hFFFF_0000 | 32'(i*16'h0101));
      chk("R6 config output", cfg_out(i), {16'(i*16'h0101), 16'(i*16'h1111)});
      rd(8'(i*8 + 4), v);
      chk("R6 config readback", v, 32'(16'(i*16'h0101)));
    end
  endtask

  task automatic t_ro();
    logic [31:0] v;
    stat = 32'h1234_5678; raw = 32'h9ABC_DEF0;
    rd(8'h50, v); chk("R7 status low", v, 32'h0000_5678);
    rd(8'h54, v); chk("R7 status high", v, 32'h0000_1234);
    rd(8'h5C, v); chk("R7 raw high", v, 32'h0000_9ABC);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h58, 32'hFFFF_0000);
    wr(8'h70, 32'hFFFF_FFFF);
    chk("R7 pin_o after ro writes", pin_out, 32'hA5A5_1234);
    chk("R7 pin_oe after ro writes", pin_oe, 32'h8000_000F);
    rd(8'h50, v); chk("R7 status still input", v, 32'h0000_5678);
  endtask

  task automatic t_sync();
    @(negedge clk);
    pin_in = 32'hCAFE_BABE; addr = 8'h70;
    @(negedge clk);
    chk("R8 one edge: old value", rdata, 32'h0000_0000);
    @(negedge clk);
    chk("R8 two edges: new low", rdata, 32'h0000_BABE);
    addr = 8'h74;
    #1 chk("R8 new high", rdata, 32'h0000_CAFE);
  endtask

  task automatic t_eoi();
    logic [31:0] v;
    @(negedge clk);
    addr = 8'h64; wdata = 32'h0005_FFFF; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R9 eoi pulse", eoi, 32'h0005_0000);
    @(negedge clk);
    chk("R9 eoi cleared", eoi, 32'h0);
    rd(8'h60, v); chk("R9 eoi reads zero", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h40, v); chk("R10 gap read", v, 0);
    rd(8'h80, v); chk("R10 high read", v, 0);
    rd(8'h01, v); chk("R10 misaligned read", v, 0);
    wr(8'h01, 32'hFFFF_0000);
    chk("R10 misaligned write", pin_out, 32'hA5A5_1234);
    wr(8'h88, 32'hFFFF_0000);
    chk("R10 high write", pin_oe, 32'h8000_000F);
    wr(8'h48, 32'hFFFF_FFFF);
    chk("R10 gap write", pin_out, 32'hA5A5_1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_halves();
    t_dir();
    t_cfg();
    t_ro();
    t_sync();
    t_eoi();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule